// File: doc/BRIEF.md
# Lazy quadratic-extension twist accumulator

This block sits in one residue channel of a residue-number-system multiplier and builds up the unreduced coefficients of a degree-twelve extension product. That product is written as a polynomial of degree five in W over the quadratic extension, with W^6 = ζ and ζ = 1 + i. Each input beat carries one coefficient pair (j, k) and the four channel products of the two quadratic coefficients: real·real, imag·imag, real·imag and imag·real. The block combines them schoolbook style, with no pre-additions, because in a residue channel an addition costs as much as a multiplication.

The same four products feed a real accumulator and an imaginary accumulator in the same cycle. When j + k stays below six, the pair adds to output index j + k. Otherwise it wraps to index j + k − 6 and is scaled by ζ on the way, and both parts of that scaled term are formed at once from the one product set. Six accumulator pairs hold the twelve channel values that the reductions downstream consume. Every sum is kept in the range [0, MOD). A subtraction adds the modulus complement, so no stored value ever goes negative.

A beat flagged as the first of a product restarts all six pairs. A beat flagged as the last makes the twelve results available, marked by a one-cycle valid pulse.

Top module: `fp2_lazy_mac`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `out_valid` is 0 and every field of `out_re` and `out_im` is 0.
- R2: An accepted beat (`in_valid` = 1) with j + k < NCOEF adds (p_rr − p_ii) to the real part and (p_ri + p_ir) to the imaginary part of coefficient j + k. Coefficient c sits in bits [c·W +: W] of each output bus.
- R3: An accepted beat with j + k ≥ NCOEF writes to coefficient j + k − NCOEF. With a = p_rr − p_ii and b = p_ri + p_ir, it adds a − b to the real part and a + b to the imaginary part.
- R4: All arithmetic is modulo MOD. For product inputs below MOD, every output field stays in [0, MOD), including when a subtraction underflows or a sum overflows.
- R5: An accepted beat with `clear` = 1 discards every earlier sum. After it, each coefficient holds only that beat's contribution.
- R6: `out_valid` is 1 in exactly the cycle after an accepted beat with `last` = 1, and 0 in every other cycle. In that cycle the outputs hold the sums that include the last beat.
- R7: In cycles with `in_valid` = 0, the outputs do not change, whatever the other inputs carry.
- R8: An accepted beat with j ≥ NCOEF or k ≥ NCOEF adds nothing to any coefficient. Its `clear` and `last` flags still take effect.
- R9: Streaming all NCOEF×NCOEF pairs of two extension elements, in any order, with `clear` on the first beat and `last` on the final beat, yields the extension product's coefficients reduced modulo MOD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Beat accepted this cycle |
| clear | input | 1 | Beat starts a new product |
| last | input | 1 | Beat ends the product |
| j_idx | input | IW | Coefficient index of the first operand |
| k_idx | input | IW | Coefficient index of the second operand |
| p_rr | input | W | Real·real channel product |
| p_ii | input | W | Imag·imag channel product |
| p_ri | input | W | Real·imag channel product |
| p_ir | input | W | Imag·real channel product |
| out_valid | output | 1 | Results present |
| out_re | output | NCOEF·W | Real parts, coefficient c at [c·W +: W] |
| out_im | output | NCOEF·W | Imaginary parts, coefficient c at [c·W +: W] |

## Verification
The hardest state to reach from the ports is a coefficient that collects several wrapped, ζ-scaled terms whose subtractions underflow while their additions exceed the modulus, all in the same running sum. Directed beats with products at zero and at MOD − 1 force both boundaries within one term. Whole 6×6 sweeps with random operands, fed in shuffled order, mix wrapped and unwrapped terms on every index. A second sweep started with `clear` shows that no stale sum survives. Idle cycles carrying random garbage, and beats with out-of-range indices, confirm that the outputs do not move.

// File: rtl/fp2_lazy_mac.sv
module fp2_lazy_mac #(
  parameter int W     = 8,
  parameter int MOD   = 251,
  parameter int NCOEF = 6,
  localparam int IW   = $clog2(NCOEF)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               clear,
  input  logic               last,
  input  logic [IW-1:0]      j_idx,
  input  logic [IW-1:0]      k_idx,
  input  logic [W-1:0]       p_rr,
  input  logic [W-1:0]       p_ii,
  input  logic [W-1:0]       p_ri,
  input  logic [W-1:0]       p_ir,
  output logic               out_valid,
  output logic [NCOEF*W-1:0] out_re,
  output logic [NCOEF*W-1:0] out_im
);

  localparam logic [W:0]  MODW = (W+1)'(MOD);
  localparam logic [IW:0] NC   = (IW+1)'(NCOEF);

  function automatic logic [W-1:0] add_mod(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s;
    s = {1'b0, x} + {1'b0, y};
    return (s >= MODW) ? W'(s - MODW) : W'(s);
  endfunction

  function automatic logic [W-1:0] sub_mod(input logic [W-1:0] x, input logic [W-1:0] y);
    return (x >= y) ? (x - y) : W'({1'b0, x} + MODW - {1'b0, y});
  endfunction

  logic [W-1:0] acc_re [NCOEF];
  logic [W-1:0] acc_im [NCOEF];

  logic [IW:0] ksum, tgt;
  logic        wrap, in_rng;
  logic [W-1:0] a_part, b_part, d_re, d_im;

  assign in_rng = ({1'b0, j_idx} < NC) && ({1'b0, k_idx} < NC);
  assign ksum   = {1'b0, j_idx} + {1'b0, k_idx};
  assign wrap   = ksum >= NC;
  assign tgt    = wrap ? ksum - NC : ksum;

  assign a_part = sub_mod(p_rr, p_ii);
  assign b_part = add_mod(p_ri, p_ir);
  assign d_re   = wrap ? sub_mod(a_part, b_part) : a_part;
  assign d_im   = wrap ? add_mod(a_part, b_part) : b_part;

  for (genvar c = 0; c < NCOEF; c++) begin : g_coef
    logic         hit;
    logic [W-1:0] base_re, base_im;
    assign hit     = in_rng && (tgt == (IW+1)'(c));
    assign base_re = clear ? '0 : acc_re[c];
    assign base_im = clear ? '0 : acc_im[c];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc_re[c] <= '0;
        acc_im[c] <= '0;
      end else if (in_valid) begin
        acc_re[c] <= hit ? add_mod(base_re, d_re) : base_re;
        acc_im[c] <= hit ? add_mod(base_im, d_im) : base_im;
      end
    end

    assign out_re[c*W +: W] = acc_re[c];
    assign out_im[c*W +: W] = acc_im[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid && last;
  end

endmodule

module fp2_lazy_mac_chk #(
  parameter int W     = 8,
  parameter int MOD   = 251,
  parameter int NCOEF = 6,
  localparam int IW   = $clog2(NCOEF)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               clear,
  input logic               last,
  input logic [IW-1:0]      j_idx,
  input logic [IW-1:0]      k_idx,
  input logic               out_valid,
  input logic [NCOEF*W-1:0] out_re,
  input logic [NCOEF*W-1:0] out_im
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_re == '0 && out_im == '0));

  // R6
  valid_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && last) |=> out_valid);

  // R6
  valid_only_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && last) |=> !out_valid);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_re) && $stable(out_im)));

  // R8
  bad_index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clear && (int'(j_idx) >= NCOEF || int'(k_idx) >= NCOEF))
      |=> ($stable(out_re) && $stable(out_im)));

  for (genvar c = 0; c < NCOEF; c++) begin : g_rng
    // R4
    field_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(out_re[c*W +: W]) < MOD) && (int'(out_im[c*W +: W]) < MOD));
  end

endmodule

bind fp2_lazy_mac fp2_lazy_mac_chk #(.W(W), .MOD(MOD), .NCOEF(NCOEF)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .clear(clear), .last(last),
  .j_idx(j_idx), .k_idx(k_idx), .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
);

// File: tb/test_fp2_lazy_mac.sv
module test_fp2_lazy_mac;
  localparam int W = 8, M = 251, N = 6, IW = $clog2(N);

  logic clk = 0, rst_n = 0, in_valid = 0, clear = 0, last = 0;
  logic [IW-1:0] j_idx = '0, k_idx = '0;
  logic [W-1:0]  p_rr = '0, p_ii = '0, p_ri = '0, p_ir = '0;
  logic          out_valid;
  logic [N*W-1:0] out_re, out_im;

  fp2_lazy_mac #(.W(W), .MOD(M), .NCOEF(N)) i_fp2_lazy_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .clear(clear), .last(last),
    .j_idx(j_idx), .k_idx(k_idx), .p_rr(p_rr), .p_ii(p_ii), .p_ri(p_ri), .p_ir(p_ir),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im));

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int er[N], ei[N];
  int fr[N], fi[N], gr[N], gi[N];

  function automatic int md(input int x);
    return ((x % M) + M) % M;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < N; c++) begin
      chk({tag, " re"}, int'(out_re[c*W +: W]), er[c]);
      chk({tag, " im"}, int'(out_im[c*W +: W]), ei[c]);
    end
  endtask

  task automatic clr_exp();
    for (int c = 0; c < N; c++) begin er[c] = 0; ei[c] = 0; end
  endtask

  task automatic send(input int j, input int k, input int rr, input int ii,
                      input int ri, input int ir, input bit c, input bit l);
    @(negedge clk);
    in_valid = 1; clear = c; last = l;
    j_idx = IW'(j); k_idx = IW'(k);
    p_rr = W'(rr); p_ii = W'(ii); p_ri = W'(ri); p_ir = W'(ir);
    @(negedge clk);
    in_valid = 0; clear = 0; last = 0;
  endtask

  function automatic void model_product();
    for (int c = 0; c < N; c++) begin er[c] = 0; ei[c] = 0; end
    for (int j = 0; j < N; j++)
      for (int k = 0; k < N; k++) begin
        int re, im, c;
        re = fr[j]*gr[k] - fi[j]*gi[k];
        im = fr[j]*gi[k] + fi[j]*gr[k];
        c = j + k;
        if (c >= N) begin
          int t;
          t = re - im; im = re + im; re = t; c = c - N;
        end
        er[c] = md(er[c] + re);
        ei[c] = md(ei[c] + im);
      end
  endfunction

  task automatic sweep();
    int ord[N*N];
    for (int x = 0; x < N; x++) begin
      fr[x] = $urandom % M; fi[x] = $urandom % M;
      gr[x] = $urandom % M; gi[x] = $urandom % M;
    end
    for (int x = 0; x < N*N; x++) ord[x] = x;
    for (int x = N*N-1; x > 0; x--) begin
      int y, t;
      y = $urandom % (x + 1);
      t = ord[x]; ord[x] = ord[y]; ord[y] = t;
    end
    model_product();
    for (int n = 0; n < N*N; n++) begin
      int j, k;
      j = ord[n] / N; k = ord[n] % N;
      send(j, k, md(fr[j]*gr[k]), md(fi[j]*gi[k]), md(fr[j]*gi[k]), md(fi[j]*gr[k]),
           n == 0, n == N*N-1);
    end
    chk("R6 valid after last", int'(out_valid), 1);
    check_all("R9 sweep");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    clr_exp();
    chk("R1 valid in reset", int'(out_valid), 0);
    check_all("R1 reset");
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid after reset", int'(out_valid), 0);
    check_all("R1 after reset");

    // R2 plain pair, R5 clear on single beat
    send(1, 2, 10, 3, 5, 7, 1, 1);
    clr_exp(); er[3] = 7; ei[3] = 12;
    chk("R6 valid", int'(out_valid), 1);
    check_all("R2 plain pair");
    @(negedge clk);
    chk("R6 valid single cycle", int'(out_valid), 0);

    // R3 wrapped pair scaled by zeta
    send(4, 5, 20, 5, 4, 3, 1, 1);
    clr_exp(); er[3] = 8; ei[3] = 22;
    check_all("R3 wrap pair");

    // R4 modular boundaries on wrapped and plain terms
    send(5, 5, 0, M-1, M-1, M-1, 1, 0);
    chk("R6 no valid without last", int'(out_valid), 0);
    send(0, 0, 3, 200, M-1, M-1, 0, 1);
    clr_exp(); er[4] = 3; ei[4] = 250; er[0] = 54; ei[0] = 249;
    check_all("R4 modulo bounds");

    // R8 out-of-range pairs contribute nothing
    send(0, 0, 9, 2, 1, 1, 1, 0);
    send(6, 1, 77, 3, 40, 40, 0, 0);
    send(2, 7, 50, 1, 9, 9, 0, 0);
    send(0, 1, 4, 1, 2, 2, 0, 1);
    clr_exp(); er[0] = 7; ei[0] = 2; er[1] = 3; ei[1] = 4;
    check_all("R8 bad index");

    // R9 full sweeps; second sweep also checks R5 clearing of stale sums
    repeat (4) begin
      sweep();
      // R7 idle cycles with garbage inputs
      repeat (5) begin
        @(negedge clk);
        clear = 1'($urandom); last = 1'($urandom);
        j_idx = IW'($urandom % N); k_idx = IW'($urandom % N);
        p_rr = W'($urandom % M); p_ii = W'($urandom % M);
        p_ri = W'($urandom % M); p_ir = W'($urandom % M);
      end
      @(negedge clk);
      clear = 0; last = 0;
      chk("R7 idle valid", int'(out_valid), 0);
      check_all("R7 idle hold");
    end

    // R5 clear restarts after a full sweep
    send(2, 2, 30, 10, 1, 2, 1, 1);
    clr_exp(); er[4] = 20; ei[4] = 3;
    check_all("R5 clear restart");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule